// File: doc/BRIEF.md
# Three-Lane Parallel-to-Serial Frame Transmitter

This block turns a 21-bit parallel word, presented once per pixel clock period, into three serial data lanes and one forwarded frame clock. The word is cut into three 7-bit slices. Each slice leaves on its own lane at one bit per bit-clock cycle, so a whole slice goes out in each pixel period. A fourth output carries a pixel-rate clock whose edges mark where each 7-bit frame begins and ends, so a receiver can find the frame boundaries.

The block runs on the 7x bit clock. That clock is supplied from outside and is phase-related to the pixel clock. The pixel clock comes in as a sampled input, and the block captures the data word on either its rising or its falling edge, chosen by a static parameter. The captured word goes into the lane shift registers at a fixed slot boundary. A shutdown input stops the transmitter at once. While it is high, every lane and the frame clock are held at 0. After it is released, framing starts again with the next captured word.

The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `tri_lane_serializer`

## Requirements
- R1: After reset every lane and the frame clock stay at 0 until the first word has been captured with shutdown low.
- R2: Lane i carries word bits 7i through 7i+6. Lane 0 carries bits 0..6, lane 1 carries bits 7..13 and lane 2 carries bits 14..20.
- R3: Each lane sends the least significant bit of its slice first, one bit per bit-clock cycle. If a word is captured at bit-clock edge c, its slice bit k is on the lane after edge c+1+k.
- R4: Over frame slots 0..6 the frame clock follows the pattern 1,1,0,0,0,1,1. Slot 0 is the cycle that carries slice bit 0.
- R5: With CAPTURE_EDGE = CAP_RISE the word is taken at the first bit-clock edge that samples the pixel clock high after it was low. With CAP_FALL it is taken at the first edge that samples it low after it was high.
- R6: While shutdown is 1, all lanes and the frame clock read 0 in the same cycle, and pixel-clock edges capture nothing.
- R7: After shutdown falls, the outputs stay 0 until the next captured word. That word begins a new frame at slot 0.
- R8: When words are captured every 7 bit-clock cycles, the frames follow one another with no gap, no lost word and no repeated word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 7x bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled on clk |
| shutdown | input | 1 | Forces all outputs to 0 and idles the block |
| data_in | input | 21 | Parallel word to transmit |
| lane_out | output | 3 | Serial data lanes, index = lane number |
| fclk_out | output | 1 | Forwarded frame clock |

## Verification
The lanes are driven with words of all zeros, all ones and the two alternating patterns, then a walking one, then random words. All zeros and all ones expose stuck bits. The alternating patterns separate LSB-first order from MSB-first order. The walking one shows which bit lands on which lane and in which slot. Two instances share the same pixel clock and data, one set for rising-edge capture and one for falling-edge capture, so a wrong edge choice shows up as an offset in frame timing. Shutdown is applied in a long window, in a three-cycle window and in a random-length window at random frame phases, which checks both the immediate quieting of the outputs and the restart on the next captured word.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic {CAP_RISE = 1'b0, CAP_FALL = 1'b1} cap_edge_e;

  // Frame clock level per slot: high in the two first and two last slots.
  function automatic logic frame_clk_level(input int slot, input int frame_bits);
    return (slot < 2) || (slot >= frame_bits - 2);
  endfunction
endpackage

// File: rtl/fs_rst_sync.sv
module fs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/fs_capture.sv
module fs_capture #(
  parameter int WORD_W = 21,
  parameter fs_pkg::cap_edge_e EDGE = fs_pkg::CAP_RISE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_clk,
  input  logic              shutdown,
  input  logic [WORD_W-1:0] data_in,
  output logic [WORD_W-1:0] hold_o,
  output logic              cap_o
);
  logic              pix_q;
  logic              edge_hit;
  logic [WORD_W-1:0] hold_q, hold_d;

  generate
    if (EDGE == fs_pkg::CAP_FALL) begin : g_fall
      assign edge_hit = pix_q & ~pix_clk;
    end else begin : g_rise
      assign edge_hit = ~pix_q & pix_clk;
    end
  endgenerate

  assign cap_o = edge_hit & ~shutdown;

  always_comb begin
    hold_d = hold_q;
    if (cap_o) hold_d = data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      pix_q  <= pix_clk;
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/fs_frame_ctl.sv
module fs_frame_ctl #(
  parameter int FRAME_BITS = 7,
  localparam int SLOT_W = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shutdown,
  input  logic              cap,
  output logic              load_o,
  output logic              run_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BITS - 1);

  logic              run_q, run_d;
  logic              pend_q, pend_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              load;

  always_comb begin
    load   = ~shutdown & (run_q ? (slot_q == LAST_SLOT) : pend_q);
    run_d  = run_q;
    pend_d = pend_q;
    slot_d = slot_q;
    if (shutdown) begin
      run_d  = 1'b0;
      pend_d = 1'b0;
      slot_d = '0;
    end else begin
      if (cap) pend_d = 1'b1;
      if (load) begin
        run_d  = 1'b1;
        slot_d = '0;
      end else if (run_q) begin
        slot_d = slot_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      slot_q <= '0;
    end else begin
      run_q  <= run_d;
      pend_q <= pend_d;
      slot_q <= slot_d;
    end
  end

  assign load_o = load;
  assign run_o  = run_q;
  assign slot_o = slot_q;
endmodule

// File: rtl/fs_lane.sv
module fs_lane #(
  parameter int FRAME_BITS = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shutdown,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] slice,
  output logic                  bit_o
);
  logic [FRAME_BITS-1:0] sh_q, sh_d;

  always_comb begin
    if (shutdown)  sh_d = '0;
    else if (load) sh_d = slice;
    else           sh_d = {1'b0, sh_q[FRAME_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/tri_lane_serializer.sv
module tri_lane_serializer #(
  parameter int LANE_COUNT = 3,
  parameter int FRAME_BITS = 7,
  parameter fs_pkg::cap_edge_e CAPTURE_EDGE = fs_pkg::CAP_RISE
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             pix_clk,
  input  logic                             shutdown,
  input  logic [LANE_COUNT*FRAME_BITS-1:0] data_in,
  output logic [LANE_COUNT-1:0]            lane_out,
  output logic                             fclk_out
);
  localparam int WORD_W = LANE_COUNT * FRAME_BITS;
  localparam int SLOT_W = $clog2(FRAME_BITS);

  logic              rst_n_sync;
  logic [WORD_W-1:0] hold;
  logic              cap;
  logic              load;
  logic              run;
  logic [SLOT_W-1:0] slot;
  logic [LANE_COUNT-1:0] lane_bit;

  fs_rst_sync u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_n_out (rst_n_sync)
  );

  fs_capture #(.WORD_W(WORD_W), .EDGE(CAPTURE_EDGE)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .pix_clk  (pix_clk),
    .shutdown (shutdown),
    .data_in  (data_in),
    .hold_o   (hold),
    .cap_o    (cap)
  );

  fs_frame_ctl #(.FRAME_BITS(FRAME_BITS)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .shutdown (shutdown),
    .cap      (cap),
    .load_o   (load),
    .run_o    (run),
    .slot_o   (slot)
  );

  generate
    for (genvar g = 0; g < LANE_COUNT; g++) begin : g_lane
      fs_lane #(.FRAME_BITS(FRAME_BITS)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n_sync),
        .shutdown (shutdown),
        .load     (load),
        .slice    (hold[g*FRAME_BITS +: FRAME_BITS]),
        .bit_o    (lane_bit[g])
      );
      assign lane_out[g] = lane_bit[g] & ~shutdown;
    end
  endgenerate

  assign fclk_out = run & ~shutdown &
                    fs_pkg::frame_clk_level(int'(slot), FRAME_BITS);
endmodule

// File: rtl/tri_lane_serializer_chk.sv
module tri_lane_serializer_chk #(
  parameter int LANE_COUNT = 3,
  parameter int FRAME_BITS = 7,
  localparam int SLOT_W = $clog2(FRAME_BITS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  shutdown,
  input logic                  run,
  input logic [SLOT_W-1:0]     slot,
  input logic [LANE_COUNT-1:0] lane_out,
  input logic                  fclk_out
);
  assert_quiet_shutdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (lane_out == '0 && !fclk_out));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (lane_out == '0 && !fclk_out));

  assert_start_slot0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> slot == '0);

  assert_slot_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(shutdown)) |->
      (int'(slot) == ((int'($past(slot)) == FRAME_BITS - 1) ? 0 : int'($past(slot)) + 1)));

  assert_fclk_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fclk_out) && !shutdown) |-> int'(slot) == 2);

  assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot) < FRAME_BITS);
endmodule

bind tri_lane_serializer tri_lane_serializer_chk #(
  .LANE_COUNT(LANE_COUNT), .FRAME_BITS(FRAME_BITS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shutdown (shutdown),
  .run      (run),
  .slot     (slot),
  .lane_out (lane_out),
  .fclk_out (fclk_out)
);

// File: tb/tri_lane_serializer_test.sv
module tri_lane_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int FB = 7;
  localparam int NL = 3;
  localparam int END_CYC = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_clk = 1'b0;
  logic shutdown = 1'b1;
  logic [NL*FB-1:0] data_in = '0;
  logic [NL-1:0] lane_r, lane_f;
  logic fclk_r, fclk_f;

  int errors = 0;
  int checks = 0;
  int n = 0;
  int ph = 6;
  int frame_no = 0;
  int sd_len = 0;
  bit done = 0;
  bit pix_prev = 0;

  bit               act [2];
  int               slot[2];
  logic [NL*FB-1:0] word[2];
  bit               pv  [2];
  logic [NL*FB-1:0] pw  [2];
  bit               ever[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_lane_serializer #(.CAPTURE_EDGE(fs_pkg::CAP_RISE)) uut (
    .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk), .shutdown(shutdown),
    .data_in(data_in), .lane_out(lane_r), .fclk_out(fclk_r));

  tri_lane_serializer #(.CAPTURE_EDGE(fs_pkg::CAP_FALL)) uut_fall (
    .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk), .shutdown(shutdown),
    .data_in(data_in), .lane_out(lane_f), .fclk_out(fclk_f));

  function automatic bit exp_fclk(int s);
    return (s < 2) || (s >= FB - 2);
  endfunction

  function automatic logic [NL*FB-1:0] pick_word(int f);
    case (f)
      0: return '0;
      1: return '1;
      2: return 21'h155555;
      3: return 21'h0AAAAA;
      default:
        if (f < 4 + NL*FB) return 21'(1) << (f - 4);
        else return 21'($urandom);
    endcase
  endfunction

  task automatic check_bit(input string tag, input logic act_v, input logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%b expected=%b", tag, n, act_v, exp_v);
    end
  endtask

  // Reference model: advances on the same edges, built from the requirements.
  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      bit capt;
      if (shutdown || !rst_n) begin
        act[i] = 0;
        pv[i]  = 0;
      end else if (pv[i]) begin
        act[i]  = 1;
        ever[i] = 1;
        slot[i] = 0;
        word[i] = pw[i];
      end else if (act[i]) begin
        slot[i] = (slot[i] + 1) % FB;
      end
      capt  = (i == 0) ? (pix_clk && !pix_prev) : (!pix_clk && pix_prev);
      pv[i] = !shutdown && rst_n && capt;
      pw[i] = data_in;
    end
    pix_prev = pix_clk;
  end

  always @(negedge clk) begin
    if (!done) begin
      n++;
      if (!rst_n) begin
        for (int l = 0; l < NL; l++) check_bit("R1 reset lane", lane_r[l], 1'b0);
        check_bit("R1 reset fclk", fclk_r, 1'b0);
      end else if (n > 8) begin
        for (int i = 0; i < 2; i++) begin
          logic [NL-1:0] lv;
          logic          fv;
          string         tag;
          lv = (i == 0) ? lane_r : lane_f;
          fv = (i == 0) ? fclk_r : fclk_f;
          if (shutdown)     tag = "R6 shutdown";
          else if (!act[i]) tag = ever[i] ? "R7 idle after release" : "R1 idle before first word";
          else              tag = (i == 0) ? "R2 R3 R8 lane data" : "R5 falling capture";
          for (int l = 0; l < NL; l++)
            check_bit(tag, lv[l], (act[i] && !shutdown) ? word[i][l*FB + slot[i]] : 1'b0);
          check_bit(act[i] && !shutdown ? "R4 frame clock" : tag, fv,
                    (act[i] && !shutdown) ? exp_fclk(slot[i]) : 1'b0);
        end
      end
      // drive next stimulus
      if (n == 3) rst_n = 1'b1;
      ph = (ph + 1) % FB;
      pix_clk = (ph < 4);
      if (ph == 0) begin
        data_in = pick_word(frame_no);
        frame_no++;
      end
      if (n == 1190) sd_len = 5 + ($urandom % 20);
      shutdown = (n < 12) || (n >= 300 && n < 340) || (n >= 702 && n < 705) ||
                 (n >= 1200 && n < 1200 + sd_len);
      if (n == END_CYC) begin
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1D5EED));
    for (int i = 0; i < 2; i++) begin
      act[i] = 0; slot[i] = 0; word[i] = '0; pv[i] = 0; pw[i] = '0; ever[i] = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule